// File: doc/BRIEF.md
# Timer Clock Source Selector

This block decides, for each of two timer/counters, in which system clock cycles the counter may advance. It produces one registered count-enable strobe per timer. Every strobe lasts exactly one system clock cycle. A single free-running prescaler counter runs on the system clock and is shared by both timers. It supplies divide-by-8, 64, 256 and 1024 ticks. A synchronous clear input restarts it from zero, so software can align the divided ticks to a known point in time.

Each timer also has its own external clock pin. Two flip-flops synchronize the pin. A small two-state edge tracker then follows the synchronized level. Its states are `PIN_LOW` and `PIN_HIGH`. The transition `PIN_LOW -> PIN_HIGH` marks a rising edge and `PIN_HIGH -> PIN_LOW` marks a falling edge. With no change, the tracker stays in its current state. External edges never pass through the prescaler. A 3-bit select field for each timer picks the source, and a registered multiplexer turns that source into the strobe.

The select codes are: 0 off, 1 every cycle, 2 /8, 3 /64, 4 /256, 5 /1024, 6 external falling edge, 7 external rising edge. Timer t uses select bits `[3t+2:3t]` and pin bit t.

Top module: `tmr_clk_src`

## Requirements
- R1: While `rst_n` is low, every `cnt_en` bit is 0 and the prescaler is held at zero. The prescaler value seen in the first cycle after the release edge is zero, so with code 2 the first strobe appears after the 8th rising edge that follows the release.
- R2: With select code 0, the timer's `cnt_en` stays 0 whatever the prescaler and the pin are doing.
- R3: With select code 1, the timer's `cnt_en` is 1 after every rising edge at which code 1 was present.
- R4: Codes 2, 3, 4 and 5 give strobes exactly every 8, 64, 256 and 1024 cycles. A strobe is registered at the edge that ends a cycle in which the low 3, 6, 8 or 10 prescaler bits are all ones.
- R5: A cycle with `presc_clr` high produces no divided strobe, and the prescaler is zero in the following cycle. The first /N strobe after a clear is therefore registered N edges after the clearing edge, for both timers.
- R6: Two timers with the same code from 1 to 5 strobe in the same cycles, because they share the prescaler.
- R7: Code 7 gives exactly one strobe per low-to-high pin change, and code 6 gives exactly one per high-to-low change. No division is applied to either.
- R8: A pin level first sampled at rising edge k, and different from the level sampled at edge k-1, is registered on `cnt_en` at edge k+2. A pin change made mid-cycle therefore appears 2.5 periods later.
- R9: A new select code takes effect at the next rising edge. Changing the code while the pin is stable never creates an extra strobe.
- R10: The edge tracker runs whatever code is selected. An edge that occurred while another code was selected is delivered only if the edge-coded select is present at the cycle the strobe is due. It is never replayed later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_clr | input | 1 | Synchronous clear of the shared prescaler |
| tmr_sel | input | 3*NUM_TMR | Source select codes, 3 bits per timer |
| ext_clk | input | NUM_TMR | External clock pin per timer |
| cnt_en | output | NUM_TMR | One-cycle count-enable strobe per timer |

## Verification
A prescaler that is off by one count shows up as a divided strobe in the wrong cycle. For /8 this appears within eight cycles of reset or of a clear, and for /1024 within 1024 cycles. A stuck or mis-ordered synchronizer stage, or a tracker left in the wrong state, shows up as a missing, doubled or early external strobe within three cycles of the pin change. A bad select decode is visible at the first registered strobe after the code is applied. The bench predicts the enable for each cycle from the requirements and compares it with the port one edge later.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    typedef enum logic [2:0] {
        SRC_OFF      = 3'd0,
        SRC_SYS      = 3'd1,
        SRC_DIV8     = 3'd2,
        SRC_DIV64    = 3'd3,
        SRC_DIV256   = 3'd4,
        SRC_DIV1024  = 3'd5,
        SRC_EXT_FALL = 3'd6,
        SRC_EXT_RISE = 3'd7
    } src_sel_e;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    localparam int NUM_TAPS = 4;
    localparam int SEL_W    = 3;

    // Number of prescaler bits that must all be ones for tap idx.
    function automatic int tap_log2(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
    parameter int PRESC_W = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    output logic [tcs_pkg::NUM_TAPS-1:0] tap_o
);
    logic [PRESC_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRESC_W'(1);
        end
    end

    // A tap fires when all bits below it are ones; a clear cycle is silent.
    for (genvar i = 0; i < tcs_pkg::NUM_TAPS; i++) begin : g_tap
        localparam int LW = tcs_pkg::tap_log2(i);
        assign tap_o[i] = (&cnt_q[LW-1:0]) & ~clr;
    end

endmodule

// File: rtl/tcs_ext_edge.sv
module tcs_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    import tcs_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    pin_state_e             state_q;
    pin_state_e             state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
        end
    end

    assign lvl = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and edge outputs
    always_comb begin
        state_d = state_q;
        rise_o  = 1'b0;
        fall_o  = 1'b0;
        unique case (state_q)
            PIN_LOW: begin
                if (lvl) begin
                    state_d = PIN_HIGH;
                    rise_o  = 1'b1;
                end
            end
            PIN_HIGH: begin
                if (!lvl) begin
                    state_d = PIN_LOW;
                    fall_o  = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/tcs_src_mux.sv
module tcs_src_mux (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [tcs_pkg::SEL_W-1:0]    sel_i,
    input  logic [tcs_pkg::NUM_TAPS-1:0] tap_i,
    input  logic                         rise_i,
    input  logic                         fall_i,
    output logic                         cnt_en_o
);
    import tcs_pkg::*;

    src_sel_e src;
    logic     hit;

    assign src = src_sel_e'(sel_i);

    always_comb begin
        hit = 1'b0;
        unique case (src)
            SRC_OFF:      hit = 1'b0;
            SRC_SYS:      hit = 1'b1;
            SRC_DIV8:     hit = tap_i[0];
            SRC_DIV64:    hit = tap_i[1];
            SRC_DIV256:   hit = tap_i[2];
            SRC_DIV1024:  hit = tap_i[3];
            SRC_EXT_FALL: hit = fall_i;
            SRC_EXT_RISE: hit = rise_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_en_o <= 1'b0;
        end else begin
            cnt_en_o <= hit;
        end
    end

endmodule

// File: rtl/tmr_clk_src.sv
module tmr_clk_src #(
    parameter int NUM_TMR     = 2,
    parameter int PRESC_W     = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              presc_clr,
    input  logic [NUM_TMR*tcs_pkg::SEL_W-1:0] tmr_sel,
    input  logic [NUM_TMR-1:0]                ext_clk,
    output logic [NUM_TMR-1:0]                cnt_en
);
    localparam int SW = tcs_pkg::SEL_W;

    logic [tcs_pkg::NUM_TAPS-1:0] taps;
    logic [NUM_TMR-1:0]           ext_rise;
    logic [NUM_TMR-1:0]           ext_fall;

    tcs_prescaler #(
        .PRESC_W (PRESC_W)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (presc_clr),
        .tap_o (taps)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        tcs_ext_edge #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (ext_clk[t]),
            .rise_o (ext_rise[t]),
            .fall_o (ext_fall[t])
        );

        tcs_src_mux u_mux (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_i    (tmr_sel[t*SW +: SW]),
            .tap_i    (taps),
            .rise_i   (ext_rise[t]),
            .fall_i   (ext_fall[t]),
            .cnt_en_o (cnt_en[t])
        );
    end

endmodule

// File: rtl/tcs_clk_src_chk.sv
module tcs_clk_src_chk #(
    parameter int NUM_TMR = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              presc_clr,
    input logic [NUM_TMR*tcs_pkg::SEL_W-1:0] tmr_sel,
    input logic [tcs_pkg::NUM_TAPS-1:0]      taps_i,
    input logic [NUM_TMR-1:0]                rise_i,
    input logic [NUM_TMR-1:0]                fall_i,
    input logic [NUM_TMR-1:0]                cnt_en
);
    localparam int SW = tcs_pkg::SEL_W;

    // R5: the cycle after a clear starts from zero, so no /8 tick
    a_r5_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        presc_clr |=> !taps_i[0]);

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
        a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_sel[t*SW +: SW] == 3'd0) |=> !cnt_en[t]);

        a_r3_sys_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_sel[t*SW +: SW] == 3'd1) |=> cnt_en[t]);

        a_r4_div8_only_on_tap: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_sel[t*SW +: SW] == 3'd2 && !taps_i[0]) |=> !cnt_en[t]);

        a_r4_div1024_only_on_tap: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_sel[t*SW +: SW] == 3'd5 && !taps_i[3]) |=> !cnt_en[t]);

        a_r7_rise_delivered: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_sel[t*SW +: SW] == 3'd7 && rise_i[t]) |=> cnt_en[t]);

        a_r7_fall_delivered: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_sel[t*SW +: SW] == 3'd6 && fall_i[t]) |=> cnt_en[t]);

        a_r10_no_edge_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_sel[t*SW +: SW] == 3'd7 && !rise_i[t]) |=> !cnt_en[t]);

        a_r7_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({rise_i[t], fall_i[t]}));
    end

    if (NUM_TMR >= 2) begin : g_shared
        a_r6_shared_divider: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_sel[SW-1:0] == tmr_sel[2*SW-1:SW] &&
             tmr_sel[SW-1:0] != 3'd0 && tmr_sel[SW-1:0] <= 3'd5)
            |=> (cnt_en[0] == cnt_en[1]));
    end

endmodule

bind tmr_clk_src tcs_clk_src_chk #(
    .NUM_TMR (NUM_TMR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .presc_clr (presc_clr),
    .tmr_sel   (tmr_sel),
    .taps_i    (taps),
    .rise_i    (ext_rise),
    .fall_i    (ext_fall),
    .cnt_en    (cnt_en)
);

// File: tb/tmr_clk_src_tb_top.sv
`timescale 1ns/100ps
module tmr_clk_src_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       presc_clr = 1'b0;
    logic [5:0] tmr_sel = '0;
    logic [1:0] ext_clk = '0;
    logic [1:0] cnt_en;

    always #2.5 clk = ~clk;

    tmr_clk_src dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .presc_clr (presc_clr),
        .tmr_sel   (tmr_sel),
        .ext_clk   (ext_clk),
        .cnt_en    (cnt_en)
    );

    typedef struct {
        logic [1:0] exp;
        string      tag0;
        string      tag1;
        bit         same;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    // Bench-side stimulus state
    logic [2:0] sel_b [2];
    logic [1:0] pin_b = '0;
    logic       clr_b = 1'b0;
    logic [1:0] h1 = '0, h2 = '0, h3 = '0;
    logic [2:0] sel_prev [2];
    int         ref_cnt = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int div_of(input logic [2:0] c);
        case (c)
            3'd2:    return 8;
            3'd3:    return 64;
            3'd4:    return 256;
            default: return 1024;
        endcase
    endfunction

    // Expected strobe for one timer for the edge ending this cycle
    function automatic logic exp_of(input int t, input logic [2:0] c);
        case (c)
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd6: return h3[t] & ~h2[t];
            3'd7: return ~h3[t] & h2[t];
            default: return !clr_b && ((ref_cnt % div_of(c)) == div_of(c) - 1);
        endcase
    endfunction

    function automatic string tag_of(input int t, input logic [2:0] c, input logic e);
        if (c != sel_prev[t]) return "R9";
        case (c)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd6, 3'd7: return e ? "R8" : "R7";
            default: return clr_b ? "R5" : "R4";
        endcase
    endfunction

    // Driver: applies inputs at the falling edge and queues the expectation
    task automatic step(input string force_tag);
        item_t it;
        @(negedge clk);
        tmr_sel   = {sel_b[1], sel_b[0]};
        ext_clk   = pin_b;
        presc_clr = clr_b;
        for (int t = 0; t < 2; t++) it.exp[t] = exp_of(t, sel_b[t]);
        it.tag0 = (force_tag != "") ? force_tag : tag_of(0, sel_b[0], it.exp[0]);
        it.tag1 = (force_tag != "") ? force_tag : tag_of(1, sel_b[1], it.exp[1]);
        it.same = (sel_b[0] == sel_b[1]) && (sel_b[0] != 3'd0) && (sel_b[0] <= 3'd5);
        q.push_back(it);
        h3 = h2; h2 = h1; h1 = pin_b;
        sel_prev[0] = sel_b[0];
        sel_prev[1] = sel_b[1];
        ref_cnt = clr_b ? 0 : (ref_cnt + 1) % 1024;
    endtask

    task automatic run(input int n, input string force_tag);
        for (int i = 0; i < n; i++) step(force_tag);
    endtask

    // Monitor: compares one item per cycle, just after the rising edge
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(it.tag0, int'(cnt_en[0]), int'(it.exp[0]));
            check(it.tag1, int'(cnt_en[1]), int'(it.exp[1]));
            if (it.same) check("R6", int'(cnt_en[0]), int'(cnt_en[1]));
        end
    end

    task automatic toggle_pins(input int half0, input int half1, input int n, input string tg);
        for (int i = 0; i < n; i++) begin
            if (i % half0 == 0) pin_b[0] = ~pin_b[0];
            if (i % half1 == 0) pin_b[1] = ~pin_b[1];
            step(tg);
        end
    endtask

    initial begin
        sel_b[0] = 3'd0; sel_b[1] = 3'd0;
        sel_prev[0] = 3'd0; sel_prev[1] = 3'd0;
        // R1: outputs quiet while reset is held, even with active selects
        tmr_sel = 6'b001_001;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1", int'(cnt_en), 0);
        end
        tmr_sel = '0;
        @(negedge clk);
        rst_n = 1'b1;
        ref_cnt = 1;   // the release edge advanced the prescaler once
        sel_b[0] = 3'd2; sel_b[1] = 3'd2;
        sel_prev[0] = 3'd2; sel_prev[1] = 3'd2;
        run(20, "R1");

        // R2 and R3
        sel_b[0] = 3'd0; sel_b[1] = 3'd1;
        run(30, "");
        sel_b[0] = 3'd1; sel_b[1] = 3'd0;
        run(30, "");

        // R4 and R6: every divided code
        sel_b[0] = 3'd2; sel_b[1] = 3'd2; run(40, "");
        sel_b[0] = 3'd3; sel_b[1] = 3'd3; run(200, "");
        sel_b[0] = 3'd4; sel_b[1] = 3'd4; run(600, "");
        sel_b[0] = 3'd5; sel_b[1] = 3'd4; run(2100, "");

        // R5: clears at several counter phases
        sel_b[0] = 3'd2; sel_b[1] = 3'd3;
        for (int k = 0; k < 6; k++) begin
            run(3 + k * 5, "");
            clr_b = 1'b1; step("R5"); clr_b = 1'b0;
            run(12, "R5");
        end
        run(70, "");
        sel_b[0] = 3'd5; sel_b[1] = 3'd5;
        run(300, "");
        clr_b = 1'b1; step("R5"); clr_b = 1'b0;
        run(1100, "R5");

        // R7 and R8: external edges, different pin rates
        sel_b[0] = 3'd7; sel_b[1] = 3'd6;
        run(5, "");
        toggle_pins(2, 3, 60, "");
        toggle_pins(5, 2, 60, "");
        sel_b[0] = 3'd6; sel_b[1] = 3'd7;
        toggle_pins(3, 4, 60, "");
        run(6, "");

        // R9: select changes with stable pins
        pin_b = 2'b11;
        run(6, "");
        for (int k = 0; k < 16; k++) begin
            sel_b[0] = 3'(k % 8);
            sel_b[1] = 3'((k * 3 + 1) % 8);
            run(3, "");
        end

        // R10: edges while another code is selected are not replayed
        sel_b[0] = 3'd2; sel_b[1] = 3'd0;
        pin_b = 2'b00; step("R10");
        pin_b = 2'b11; step("R10");
        step("R10");
        sel_b[0] = 3'd7; sel_b[1] = 3'd7;
        run(8, "R10");
        pin_b = 2'b00; step("R10");
        sel_b[0] = 3'd6; sel_b[1] = 3'd1;
        run(8, "R10");

        repeat (3) @(posedge clk);
        #2;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule